// File: doc/BRIEF.md
# Up/Down Timer with Edge Capture

This block is a 16-bit timer/counter that steps by one on every count strobe while it is running, either upward or downward according to a direction control. Leaving the top of the range (upward past all ones) or the bottom (downward past zero) raises a single shared wrap flag. The flag then holds until software clears it.

A second function timestamps external events. When capture mode and capture enable are both set and the timer is running, a falling edge on the external event pin copies the live count into a capture register and raises a capture flag. The pin is asynchronous. It passes through a two-stage synchronizer before edge detection, so the capture register loads on the third rising clock edge after the pin falls. An interrupt request is active whenever interrupts are enabled and either flag is set.

Top module: `updown_capture_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `count`, `cap_val`, `wrap_flag` and `cap_flag` to zero.
- R2: With `run`=1 and `tick`=1 at a rising edge, `count` changes by exactly one. If `run`=0 or `tick`=0, `count` holds its value.
- R3: With `down`=0 the count increments. A step from 0xFFFF to 0x0000 sets `wrap_flag`.
- R4: With `down`=1 the count decrements. A step from 0x0000 to 0xFFFF sets the same `wrap_flag`.
- R5: With `cap_mode`=1, `run`=1 and `cap_en`=1, a high-to-low transition on `cap_pin` loads `count` into `cap_val` and sets `cap_flag`. The load occurs on the third rising clock edge after the pin falls.
- R6: When `cap_en`=0, falling edges on `cap_pin` are ignored, and `cap_val` and `cap_flag` stay unchanged.
- R7: A low-to-high transition on `cap_pin` never causes a capture.
- R8: When a capture and a count step occur in the same cycle, `cap_val` receives the count value from before the step.
- R9: Both flags are sticky until their clear strobe (`clr_wrap`, `clr_cap`). If a clear strobe coincides with a new set event, the flag stays set.
- R10: `irq` is 1 exactly when `irq_en`=1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable strobe |
| run | input | 1 | Run control |
| down | input | 1 | Direction select: 1 counts down |
| cap_mode | input | 1 | Selects capture operation |
| cap_en | input | 1 | Enables capture on pin edges |
| cap_pin | input | 1 | Asynchronous external capture input |
| irq_en | input | 1 | Interrupt enable |
| clr_wrap | input | 1 | Clear strobe for the wrap flag |
| clr_cap | input | 1 | Clear strobe for the capture flag |
| count | output | 16 | Live counter value |
| cap_val | output | 16 | Captured count |
| wrap_flag | output | 1 | Overflow/underflow flag |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Counting is tested in both directions, and each direction is driven across its wrap boundary so that the bench can tell an upward overflow from a downward underflow. The run bit and the tick strobe are each withheld on their own to show that either one alone stops the count.

Capture is exercised in three settings:
- with the counter frozen, which checks the value loaded and the three-edge latency;
- with a tick on every cycle, which checks that the value before the step is kept;
- with rising edges and with capture disabled, which shows that neither case captures.

Clear strobes are applied both alone and together with a wrap event, which checks that a set event wins over a clear.

// File: rtl/updown_capture_timer.sv
module updown_capture_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             down,
  input  logic             cap_mode,
  input  logic             cap_en,
  input  logic             cap_pin,
  input  logic             irq_en,
  input  logic             clr_wrap,
  input  logic             clr_cap,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cap_val,
  output logic             wrap_flag,
  output logic             cap_flag,
  output logic             irq
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic pin_s1, pin_s2, pin_prev;
  logic step, at_edge, wrap_hit, capture;

  assign step     = run & tick;
  assign at_edge  = down ? (count == '0) : (count == TOP);
  assign wrap_hit = step & at_edge;
  assign capture  = cap_mode & run & cap_en & pin_prev & ~pin_s2;
  assign irq      = irq_en & (wrap_flag | cap_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s1    <= 1'b1;
      pin_s2    <= 1'b1;
      pin_prev  <= 1'b1;
      count     <= '0;
      cap_val   <= '0;
      wrap_flag <= 1'b0;
      cap_flag  <= 1'b0;
    end else begin
      pin_s1   <= cap_pin;
      pin_s2   <= pin_s1;
      pin_prev <= pin_s2;
      if (step) count <= down ? count - 1'b1 : count + 1'b1;
      if (capture) cap_val <= count;
      wrap_flag <= wrap_hit | (wrap_flag & ~clr_wrap);
      cap_flag  <= capture  | (cap_flag & ~clr_cap);
    end
  end
endmodule

module updown_capture_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             down,
  input logic             cap_en,
  input logic             irq_en,
  input logic             clr_wrap,
  input logic             clr_cap,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] cap_val,
  input logic             wrap_flag,
  input logic             cap_flag,
  input logic             irq
);
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (count == '0 && cap_val == '0 && !wrap_flag && !cap_flag));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(run && tick) |=> $stable(count));

  a_r3_overflow: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !down && count == {WIDTH{1'b1}}) |=> (count == '0 && wrap_flag));

  a_r4_underflow: assert property (@(posedge clk) disable iff (rst)
    (run && tick && down && count == '0) |=> (count == {WIDTH{1'b1}} && wrap_flag));

  a_r6_no_capture: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> ($stable(cap_val) && (cap_flag || !$rose(cap_flag))));

  a_r9_wrap_sticky: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !clr_wrap) |=> wrap_flag);

  a_r9_cap_sticky: assert property (@(posedge clk) disable iff (rst)
    (cap_flag && !clr_cap) |=> cap_flag);

  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_en && (wrap_flag || cap_flag)) |-> irq);

  a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);
endmodule

bind updown_capture_timer updown_capture_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run), .down(down), .cap_en(cap_en),
  .irq_en(irq_en), .clr_wrap(clr_wrap), .clr_cap(clr_cap), .count(count),
  .cap_val(cap_val), .wrap_flag(wrap_flag), .cap_flag(cap_flag), .irq(irq)
);

// File: tb/tb_updown_capture_timer.sv
module tb_updown_capture_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, run = 0, down = 0, cap_mode = 0, cap_en = 0, cap_pin = 1;
  logic irq_en = 0, clr_wrap = 0, clr_cap = 0;
  logic [15:0] count, cap_val;
  logic wrap_flag, cap_flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  updown_capture_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .down(down), .cap_mode(cap_mode),
    .cap_en(cap_en), .cap_pin(cap_pin), .irq_en(irq_en), .clr_wrap(clr_wrap),
    .clr_cap(clr_cap), .count(count), .cap_val(cap_val), .wrap_flag(wrap_flag),
    .cap_flag(cap_flag), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; tick = 0; run = 0; down = 0; cap_mode = 0; cap_en = 0; cap_pin = 1;
    irq_en = 0; clr_wrap = 0; clr_cap = 0;
    cyc(2);
    rst = 0;
  endtask

  task automatic ticks(int n);
    tick = 1; cyc(n); tick = 0;
  endtask

  task automatic t_reset();
    run = 1; ticks(3); cap_mode = 1; cap_en = 1; cap_pin = 0; cyc(4);
    do_reset();
    check("R1 count", count, 0);
    check("R1 cap_val", cap_val, 0);
    check("R1 flags", {wrap_flag, cap_flag}, 0);
  endtask

  task automatic t_count_up();
    do_reset();
    run = 1; ticks(7);
    check("R2 up by 7", count, 7);
    run = 0; tick = 1; cyc(3); tick = 0;
    check("R2 run=0 holds", count, 7);
    run = 1; cyc(3);
    check("R2 tick=0 holds", count, 7);
  endtask

  task automatic t_wraps();
    do_reset();
    run = 1; down = 1; ticks(1);
    check("R4 underflow value", count, 16'hFFFF);
    check("R4 underflow flag", wrap_flag, 1);
    ticks(2);
    check("R4 down step", count, 16'hFFFD);
    clr_wrap = 1; cyc(1); clr_wrap = 0;
    check("R9 clear wrap", wrap_flag, 0);
    down = 0; ticks(2);
    check("R3 no wrap below top", {wrap_flag, count}, {1'b0, 16'hFFFF});
    ticks(1);
    check("R3 overflow value", count, 0);
    check("R3 overflow flag", wrap_flag, 1);
    cyc(3);
    check("R9 wrap sticky", wrap_flag, 1);
    ticks(1);
    clr_wrap = 1; cyc(1); clr_wrap = 0;
    check("R9 cleared again", wrap_flag, 0);
    down = 1; ticks(1);
    clr_wrap = 1; tick = 1; cyc(1); tick = 0; clr_wrap = 0;
    check("R9 set wins over clear", {wrap_flag, count}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_capture_static();
    do_reset();
    run = 1; ticks(5);
    cap_mode = 1; cap_en = 1; cyc(2);
    cap_pin = 0; cyc(2);
    check("R5 not yet after two edges", cap_flag, 0);
    cyc(1);
    check("R5 captured value", cap_val, 5);
    check("R5 capture flag", cap_flag, 1);
    clr_cap = 1; cyc(1); clr_cap = 0;
    check("R9 clear cap", cap_flag, 0);
    ticks(1);
    cap_pin = 1; cyc(5);
    check("R7 rising edge ignored", {cap_flag, cap_val}, {1'b0, 16'd5});
    cap_en = 0; cap_pin = 0; cyc(5);
    check("R6 disabled fall ignored", {cap_flag, cap_val}, {1'b0, 16'd5});
    cap_pin = 1; cyc(4);
  endtask

  task automatic t_capture_moving();
    logic [15:0] c;
    do_reset();
    run = 1; cap_mode = 1; cap_en = 1; cyc(3);
    tick = 1; cyc(10);
    cap_pin = 0; cyc(2);
    c = count;
    cyc(1);
    check("R8 pre-step value captured", cap_val, c);
    check("R8 count advanced", count, c + 16'd1);
    tick = 0; cap_pin = 1;
    cyc(1);
    clr_cap = 1; cyc(1);
    check("R9 cap clear honoured", cap_flag, 0);
    cap_pin = 0; cyc(2);
    clr_cap = 1; cyc(1); clr_cap = 0;
    check("R9 cap set wins over clear", cap_flag, 1);
    cap_pin = 1; cyc(3);
  endtask

  task automatic t_irq();
    do_reset();
    check("R10 idle low", irq, 0);
    run = 1; down = 1; ticks(1);
    check("R10 masked", irq, 0);
    irq_en = 1; #1;
    check("R10 wrap raises", irq, 1);
    clr_wrap = 1; cyc(1); clr_wrap = 0;
    check("R10 drops after clear", irq, 0);
    cap_mode = 1; cap_en = 1; cap_pin = 0; cyc(3);
    check("R10 capture raises", irq, 1);
  endtask

  initial begin
    t_reset();
    t_count_up();
    t_wraps();
    t_capture_static();
    t_capture_moving();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule